// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit accumulator processor. Each cycle it receives the current accumulator value, one operand byte and a 4-bit operation code. It returns the new accumulator value without any clock delay. It also returns a write-enable that tells the register file whether to store that value. Four condition flags are kept in an internal register: zero (Z), subtract (N), half-carry (H) and carry (C). The flags are updated on the clock edge that ends an issued operation.

The stored carry is the carry-in for add-with-carry and subtract-with-borrow. The stored N, H and C flags steer the decimal-adjust correction that follows a BCD add or subtract. Operand fetch, memory access, instruction decode and cycle counting belong to the surrounding core.

Top module: `acc_alu8`

## Requirements
- R1: After reset the flag register reads 0x00. Its layout is Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 always read 0.
- R2: Add (op 0x0) and add-with-carry (op 0x1, carry-in = stored C) write A+B(+cin) modulo 256 and clear N. They set C when the 9-bit sum exceeds 0xFF. They set H when the low-nibble sum including the carry-in exceeds 0xF. They set Z when the 8-bit result is zero.
- R3: Subtract (op 0x2) and subtract-with-borrow (op 0x3, borrow-in = stored C) write A-B(-cin) modulo 256 and set N. They set C on a borrow out of bit 7. They set H when the low-nibble difference including the borrow-in is negative. Z follows the 8-bit result.
- R4: Compare (op 0x7) sets Z, N, H and C exactly as a subtract would. It keeps the write-enable low and presents the unchanged accumulator.
- R5: AND (op 0x4) writes A&B, sets H, clears N and C, and sets Z from the result.
- R6: XOR (op 0x5) and OR (op 0x6) write the result, clear N, H and C, and set Z from the result.
- R7: Decimal adjust (op 0x8) forms a correction value. The correction includes 0x60 when stored C is set, or when stored N is clear and A > 0x99. It includes 0x06 when stored H is set, or when stored N is clear and A[3:0] > 9. The correction is subtracted from A when stored N is set and added otherwise.
- R8: After decimal adjust, C is set exactly when the 0x60 part was applied, H is cleared, N is preserved and Z follows the result.
- R9: Complement (op 0x9) writes ~A and sets N and H. It leaves Z and C unchanged.
- R10: Set-carry (op 0xA) forces C to 1. Complement-carry (op 0xB) inverts C. Both clear N and H, keep Z, and do not write the accumulator.
- R11: Codes 0xC to 0xF, and any cycle with the operation strobe low, leave the flags unchanged and keep the write-enable low.
- R12: The write-enable is high exactly when the strobe is high and the code is one of 0x0 to 0x6, 0x8 or 0x9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_en | input | 1 | An operation is issued this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd | input | 8 | Operand byte |
| acc_out | output | 8 | New accumulator value (combinational) |
| acc_we | output | 1 | Accumulator write-enable |
| flag_reg | output | 8 | Flag register, Z N H C in bits 7..4 |

## Verification
The checker watches, on every cycle, the rules that fix flags without arithmetic:
- the zero low nibble;
- the flag patterns of AND, OR/XOR, complement and set-carry;
- the held flags on idle or unused codes;
- the suppressed write on compare.

The bench's scenarios are the only place where the value-dependent results are shown. These are the nibble-level carry and borrow with a carry-in, and the decimal-adjust corrections after both an add and a subtract. They also include wrap to zero and the carry chaining from one operation into the next.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 4;

    localparam logic [OPW-1:0] OP_ADD = 4'h0;
    localparam logic [OPW-1:0] OP_ADC = 4'h1;
    localparam logic [OPW-1:0] OP_SUB = 4'h2;
    localparam logic [OPW-1:0] OP_SBC = 4'h3;
    localparam logic [OPW-1:0] OP_AND = 4'h4;
    localparam logic [OPW-1:0] OP_XOR = 4'h5;
    localparam logic [OPW-1:0] OP_OR  = 4'h6;
    localparam logic [OPW-1:0] OP_CMP = 4'h7;
    localparam logic [OPW-1:0] OP_DAA = 4'h8;
    localparam logic [OPW-1:0] OP_CPL = 4'h9;
    localparam logic [OPW-1:0] OP_SCF = 4'hA;
    localparam logic [OPW-1:0] OP_CCF = 4'hB;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          we;
        flags_t        fl;
    } alu_next_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = W / 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hout
);
    logic [NB:0] lo_d;
    logic [W:0]  full_d;

    always_comb begin
        if (sub) begin
            lo_d   = {1'b0, a[NB-1:0]} - {1'b0, b[NB-1:0]} - {{NB{1'b0}}, cin};
            full_d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
        end else begin
            lo_d   = {1'b0, a[NB-1:0]} + {1'b0, b[NB-1:0]} + {{NB{1'b0}}, cin};
            full_d = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        end
        res  = full_d[W-1:0];
        cout = full_d[W];
        hout = lo_d[NB];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] res
);
    always_comb begin
        case (sel)
            LG_AND:  res = a & b;
            LG_XOR:  res = a ^ b;
            default: res = a | b;
        endcase
    end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
#(
    parameter int W  = DW,
    parameter int NB = W / 2
) (
    input  logic [W-1:0] a,
    input  logic         n_in,
    input  logic         h_in,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam logic [NB-1:0] DIG_MAX = NB'(9);
    localparam logic [NB-1:0] DIG_FIX = NB'(6);
    localparam logic [W-1:0]  HI_LIM  = {DIG_MAX, DIG_MAX};

    logic          fix_hi;
    logic          fix_lo;
    logic [W-1:0]  corr;

    always_comb begin
        fix_hi = c_in | (~n_in & (a > HI_LIM));
        fix_lo = h_in | (~n_in & (a[NB-1:0] > DIG_MAX));
        corr   = {(fix_hi ? DIG_FIX : {NB{1'b0}}), (fix_lo ? DIG_FIX : {NB{1'b0}})};
        res    = n_in ? (a - corr) : (a + corr);
        c_out  = fix_hi;
    end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import alu8_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_en,
    input  logic [3:0]   op,
    input  logic [7:0]   acc_in,
    input  logic [7:0]   opnd,
    output logic [7:0]   acc_out,
    output logic         acc_we,
    output logic [7:0]   flag_reg
);
    localparam int PADW = DW - $bits(flags_t);

    flags_t     flag_q;
    alu_next_t  nx_d;

    logic          as_sub;
    logic          as_cin;
    logic [DW-1:0] as_res;
    logic          as_c;
    logic          as_h;
    logic_sel_e    lg_sel;
    logic [DW-1:0] lg_res;
    logic [DW-1:0] bcd_res;
    logic          bcd_c;

    always_comb begin
        as_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        as_cin = ((op == OP_ADC) || (op == OP_SBC)) ? flag_q.c : 1'b0;
        case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_OR;
        endcase
    end

    alu8_addsub #(.W(DW), .NB(NW)) u_addsub (
        .a(acc_in), .b(opnd), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_c), .hout(as_h)
    );

    alu8_logic #(.W(DW)) u_logic (
        .a(acc_in), .b(opnd), .sel(lg_sel), .res(lg_res)
    );

    alu8_bcd #(.W(DW), .NB(NW)) u_bcd (
        .a(acc_in), .n_in(flag_q.n), .h_in(flag_q.h), .c_in(flag_q.c),
        .res(bcd_res), .c_out(bcd_c)
    );

    always_comb begin
        nx_d.res = acc_in;
        nx_d.we  = 1'b0;
        nx_d.fl  = flag_q;
        if (op_en) begin
            case (op)
                OP_ADD, OP_ADC: begin
                    nx_d.res  = as_res;
                    nx_d.we   = 1'b1;
                    nx_d.fl.z = (as_res == '0);
                    nx_d.fl.n = 1'b0;
                    nx_d.fl.h = as_h;
                    nx_d.fl.c = as_c;
                end
                OP_SUB, OP_SBC, OP_CMP: begin
                    nx_d.res  = (op == OP_CMP) ? acc_in : as_res;
                    nx_d.we   = (op != OP_CMP);
                    nx_d.fl.z = (as_res == '0);
                    nx_d.fl.n = 1'b1;
                    nx_d.fl.h = as_h;
                    nx_d.fl.c = as_c;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    nx_d.res  = lg_res;
                    nx_d.we   = 1'b1;
                    nx_d.fl.z = (lg_res == '0);
                    nx_d.fl.n = 1'b0;
                    nx_d.fl.h = (op == OP_AND);
                    nx_d.fl.c = 1'b0;
                end
                OP_DAA: begin
                    nx_d.res  = bcd_res;
                    nx_d.we   = 1'b1;
                    nx_d.fl.z = (bcd_res == '0);
                    nx_d.fl.h = 1'b0;
                    nx_d.fl.c = bcd_c;
                end
                OP_CPL: begin
                    nx_d.res  = ~acc_in;
                    nx_d.we   = 1'b1;
                    nx_d.fl.n = 1'b1;
                    nx_d.fl.h = 1'b1;
                end
                OP_SCF, OP_CCF: begin
                    nx_d.fl.n = 1'b0;
                    nx_d.fl.h = 1'b0;
                    nx_d.fl.c = (op == OP_SCF) ? 1'b1 : ~flag_q.c;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= nx_d.fl;
        end
    end

    assign acc_out  = nx_d.res;
    assign acc_we   = nx_d.we;
    assign flag_reg = {flag_q, {PADW{1'b0}}};
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_en,
    input logic [3:0] op,
    input logic [7:0] acc_in,
    input logic [7:0] opnd,
    input logic [7:0] acc_out,
    input logic       acc_we,
    input logic [7:0] flag_reg
);
    p_low_nibble_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flag_reg[3:0] == 4'h0);

    p_sub_sets_n_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op == 4'h2 || op == 4'h3) |=> flag_reg[6]);

    p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'h7 |-> !acc_we && acc_out == acc_in);

    p_and_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'h4 |=> flag_reg[5] && !flag_reg[6] && !flag_reg[4]);

    p_or_xor_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op == 4'h5 || op == 4'h6) |=> flag_reg[6:4] == 3'b000);

    p_daa_clears_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'h8 |=> !flag_reg[5] && flag_reg[6] == $past(flag_reg[6]));

    p_cpl_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'h9 |-> acc_we && acc_out == ~acc_in);

    p_cpl_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'h9 |=> flag_reg[6] && flag_reg[5] &&
            flag_reg[7] == $past(flag_reg[7]) && flag_reg[4] == $past(flag_reg[4]));

    p_scf_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'hA |=> flag_reg[4] && flag_reg[6:5] == 2'b00 &&
            flag_reg[7] == $past(flag_reg[7]));

    p_ccf_flips_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && op == 4'hB |=> flag_reg[4] != $past(flag_reg[4]));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en || op >= 4'hC) |=> $stable(flag_reg));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_en || op >= 4'hC || op == 4'h7) |-> !acc_we);

    p_we_writers_r12: assert property (@(posedge clk) disable iff (!rst_n)
        op_en && (op <= 4'h6 || op == 4'h8 || op == 4'h9) |-> acc_we);
endmodule

bind acc_alu8 alu8_chk u_chk (.*);

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_en;
    logic [3:0] op;
    logic [7:0] acc_in;
    logic [7:0] opnd;
    logic [7:0] acc_out;
    logic       acc_we;
    logic [7:0] flag_reg;

    always #4 clk = ~clk;

    acc_alu8 u0 (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op),
        .acc_in(acc_in), .opnd(opnd),
        .acc_out(acc_out), .acc_we(acc_we), .flag_reg(flag_reg)
    );

    typedef struct {
        logic [7:0] res;
        logic       we;
        logic [7:0] fl;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    logic mz = 0, mn = 0, mh = 0, mc = 0;

    task automatic check(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: computes the expectation from the requirements, then drives.
    task automatic issue(input int o, input int a, input int b, input bit en);
        int r, s, cin, adj;
        logic z, n, h, c, we;
        string tag;
        exp_t e;
        z = mz; n = mn; h = mh; c = mc; r = a; we = 0; tag = "R11";
        if (en) begin
            case (o)
                0, 1: begin
                    cin = (o == 1) ? int'(mc) : 0;
                    s = a + b + cin;
                    h = ((a & 15) + (b & 15) + cin) > 15;
                    c = s > 255; r = s & 255; n = 0; z = (r == 0); we = 1; tag = "R2";
                end
                2, 3, 7: begin
                    cin = (o == 3) ? int'(mc) : 0;
                    s = a - b - cin;
                    c = s < 0; h = ((a & 15) - (b & 15) - cin) < 0;
                    n = 1; z = ((s & 255) == 0);
                    r = (o == 7) ? a : (s & 255);
                    we = (o != 7); tag = (o == 7) ? "R4" : "R3";
                end
                4: begin r = a & b; z = (r == 0); n = 0; h = 1; c = 0; we = 1; tag = "R5"; end
                5: begin r = a ^ b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; tag = "R6"; end
                6: begin r = a | b; z = (r == 0); n = 0; h = 0; c = 0; we = 1; tag = "R6"; end
                8: begin
                    adj = 0;
                    if (mc || (!mn && a > 'h99)) begin adj = adj | 'h60; c = 1; end
                    if (mh || (!mn && (a & 15) > 9)) adj = adj | 'h06;
                    r = mn ? ((a - adj) & 255) : ((a + adj) & 255);
                    z = (r == 0); h = 0; we = 1; tag = "R7";
                end
                9:  begin r = (~a) & 255; n = 1; h = 1; we = 1; tag = "R9"; end
                10: begin c = 1; n = 0; h = 0; tag = "R10"; end
                11: begin c = ~mc; n = 0; h = 0; tag = "R10"; end
                default: ;
            endcase
        end
        mz = z; mn = n; mh = h; mc = c;
        e.res = r[7:0]; e.we = we; e.fl = {z, n, h, c, 4'h0}; e.tag = tag;
        @(negedge clk);
        op_en = en; op = o[3:0]; acc_in = a[7:0]; opnd = b[7:0];
        q.push_back(e);
    endtask

    // Monitor: result mid-cycle, flags one cycle later.
    initial begin
        exp_t cur;
        bit pend = 0;
        logic [7:0] pfl = '0;
        string ptag = "";
        forever begin
            @(negedge clk);
            #2;
            if (pend) begin
                check(ptag, flag_reg, pfl, "flags");
                check("R1", flag_reg[3:0], 0, "low nibble");
                pend = 0;
            end
            if (q.size() > 0) begin
                cur = q.pop_front();
                check(cur.tag, acc_out, cur.res, "result");
                check("R12", acc_we, cur.we, "write enable");
                pfl = cur.fl; ptag = cur.tag; pend = 1;
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_en = 0; op = 0; acc_in = 0; opnd = 0;
        repeat (3) @(negedge clk);
        check("R1", flag_reg, 0, "reset flags");
        rst_n = 1;
        issue(0, 'h15, 'h27, 1);  // R2 plain add
        issue(8, 'h3C, 0, 1);     // R7 low-digit fix after add
        issue(0, 'hF8, 'h08, 1);  // R2 wrap to zero, H and C
        issue(1, 'h0F, 'h00, 1);  // R2 carry-in reaches nibble
        issue(1, 'h01, 'h01, 1);  // R2 carry-in clear
        issue(2, 'h42, 'h15, 1);  // R3 nibble borrow
        issue(8, 'h2D, 0, 1);     // R7 R8 subtract-side correction
        issue(10, 'h00, 0, 1);    // R10 set carry
        issue(3, 'h10, 'h0F, 1);  // R3 borrow-in gives zero
        issue(7, 'h30, 'h40, 1);  // R4 compare with borrow
        issue(11, 'h00, 0, 1);    // R10 complement carry
        issue(11, 'h00, 0, 1);    // R10 complement carry back
        issue(4, 'hF0, 'h0F, 1);  // R5 AND to zero
        issue(6, 'h00, 'h00, 1);  // R6 OR zero
        issue(8, 'h9A, 0, 1);     // R7 R8 both corrections, wrap to zero
        issue(5, 'h5A, 'hA5, 1);  // R6 XOR
        issue(9, 'h35, 0, 1);     // R9 complement
        issue(12, 'h11, 'h22, 1); // R11 unused code
        issue(15, 'h33, 'h44, 1); // R11 unused code
        issue(0, 'h80, 'h80, 0);  // R11 strobe low
        issue(0, 0, 0, 0);
        issue(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule